// File: doc/BRIEF.md
# MDIO PHY Initialization and Status Poller

This block is a self-running management master for a group of external Ethernet PHYs on a shared two-wire MDIO/MDC bus. No processor is involved. Once reset is released, it visits every port in ascending order. For each port it loads the advertised ability word into the PHY and then restarts auto-negotiation with a control write. When all ports are set up, it enters an endless round-robin poll. On each port it reads the status register and then the link-partner ability register.

After each poll the block refreshes that port's entry in a status table. The entry holds link up, 100 Mb/s speed, full duplex and pause enable. Speed and duplex are the best mode that both ends advertise. Pause is granted only when the result is full duplex. PHY addresses are contiguous: port p uses address PHY_BASE + p, and the default base is 01000b, so 16 ports cover addresses 01000b through 10111b. The management clock comes from a parameterized divider of the system clock. Frames are sent back to back, separated by at most one idle MDC period.

Top module: `phy_mgmt_master`

## Requirements
- R1: Each high level and each low level of MDC lasts exactly CLK_HALF system clocks. The default of 25 gives 2.5 MHz at 125 MHz.
- R2: mdio_o and mdio_oe change only at the system clock edge where MDC falls. They are stable for the whole time MDC is high.
- R3: Every frame is sent MSB first and has 64 bits, in this order:
  - 32 preamble ones
  - start bits 0,1
  - a 2-bit opcode: 01 for write, 10 for read
  - a 5-bit PHY address
  - a 5-bit register address
  - two turnaround bits, which a write drives as 1,0
  - 16 data bits
- R4: Initialization comes first. For port p = 0 up to NPORT-1 the block writes register 4 with ADV_WORD and then register 0 with 0x1200 (bits 12 and 9 set), both to address PHY_BASE+p. No read is issued before this finishes.
- R5: In a read frame, mdio_oe is low during both turnaround bits and all 16 data bits. The block samples mdio_i at the MDC rising edges of the data bits.
- R6: After initialization the block reads, for each port in ascending order, register 1 and then register 5. After the last port it wraps to port 0 and repeats forever.
- R7: A port's status entry is updated when the register-5 read of that port completes, and only then. Link comes from bit 2 of that poll's register-1 read.
- R8: When link is down, the port's speed, duplex and pause outputs are 0.
- R9: Let c = ADV_WORD & partner word. The block picks the first set bit in this order: c[8] (100 full), c[7] (100 half), c[6] (10 full), c[5] (10 half).
  - port_fast is 1 for either 100 Mb/s result.
  - port_full is 1 for either full-duplex result.
  - If none of these bits is set, both outputs are 0.
- R10: port_pause equals c[10] AND the resolved full duplex.
- R11: During reset, MDC, mdio_oe and all status outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mdc | output | 1 | Management clock to the PHYs |
| mdio_o | output | 1 | Management data driven by the block |
| mdio_oe | output | 1 | Output enable of the management data pin |
| mdio_i | input | 1 | Management data read from the pin |
| port_link | output | NPORT | Link up, one bit per port |
| port_fast | output | NPORT | Resolved speed is 100 Mb/s |
| port_full | output | NPORT | Resolved duplex is full |
| port_pause | output | NPORT | Pause frames enabled for the port |

## Verification
The checker watches the following on every cycle:
- each MDC phase is at least the configured length;
- the data pin and its enable move only while MDC is low;
- a port never shows speed, duplex or pause without link, and never pause without full duplex;
- no more than one port's status changes in any single cycle.

Other behaviour can only be shown by the bench's scenarios, which decode each frame against a modelled set of PHYs:
- the exact frame layout;
- the ascending order of the initialization writes and the polling reads;
- release of the pin during read turnaround;
- the priority resolution of the common abilities over a set of partner patterns that changes between two poll rounds.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

  localparam int PRE_W   = 32;
  localparam int FRAME_W = PRE_W + 32;

  localparam logic [1:0] OP_WR = 2'b01;
  localparam logic [1:0] OP_RD = 2'b10;

  localparam logic [4:0] REG_CTRL = 5'd0;
  localparam logic [4:0] REG_STAT = 5'd1;
  localparam logic [4:0] REG_ADV  = 5'd4;
  localparam logic [4:0] REG_PART = 5'd5;

  localparam logic [15:0] RESTART_WORD = 16'h1200;

  localparam int LINK_BIT  = 2;
  localparam int AB_10HD   = 5;
  localparam int AB_10FD   = 6;
  localparam int AB_100HD  = 7;
  localparam int AB_100FD  = 8;
  localparam int AB_PAUSE  = 10;

  typedef enum logic [1:0] {
    STEP_ADV,
    STEP_RESTART,
    STEP_STAT,
    STEP_PART
  } step_e;

  typedef struct packed {
    logic link;
    logic fast;
    logic full;
    logic pause;
  } port_stat_t;

  function automatic port_stat_t resolve_port(input logic up,
                                              input logic [15:0] adv,
                                              input logic [15:0] part);
    logic [15:0] common;
    port_stat_t  s;
    common = adv & part;
    s = '0;
    if (up) begin
      s.link = 1'b1;
      if (common[AB_100FD]) begin
        s.fast = 1'b1;
        s.full = 1'b1;
      end else if (common[AB_100HD]) begin
        s.fast = 1'b1;
      end else if (common[AB_10FD]) begin
        s.full = 1'b1;
      end else if (common[AB_10HD]) begin
        s.fast = 1'b0;
      end
      s.pause = s.full & common[AB_PAUSE];
    end
    return s;
  endfunction

endpackage

// File: rtl/mdc_gen.sv
module mdc_gen #(
  parameter int CLK_HALF = 25
) (
  input  logic clk,
  input  logic rst_n,
  output logic mdc,
  output logic rise_stb,
  output logic fall_stb
);

  localparam int CW = (CLK_HALF > 1) ? $clog2(CLK_HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLK_HALF - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          mdc_q, mdc_d;
  logic          wrap;

  always_comb begin
    wrap  = (cnt_q == LAST);
    cnt_d = wrap ? '0 : cnt_q + 1'b1;
    mdc_d = wrap ? ~mdc_q : mdc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  assign mdc      = mdc_q;
  assign rise_stb = wrap & ~mdc_q;
  assign fall_stb = wrap & mdc_q;

endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter
  import mdio_mgmt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rise_stb,
  input  logic        fall_stb,
  input  logic        go,
  input  logic        is_read,
  input  logic [4:0]  phy_addr,
  input  logic [4:0]  reg_addr,
  input  logic [15:0] wdata,
  input  logic        mdio_i,
  output logic        done,
  output logic [15:0] rdata,
  output logic        mdio_o,
  output logic        mdio_oe
);

  localparam int CW = $clog2(FRAME_W);
  localparam logic [CW-1:0] TA_POS   = CW'(PRE_W + 14);
  localparam logic [CW-1:0] DATA_POS = CW'(PRE_W + 16);
  localparam logic [CW-1:0] LAST_POS = CW'(FRAME_W - 1);

  logic               busy_q, busy_d;
  logic               lnch_q, lnch_d;
  logic [CW-1:0]      cnt_q, cnt_d;
  logic [FRAME_W-1:0] sh_q, sh_d;
  logic               rd_q, rd_d;
  logic [15:0]        rdat_q, rdat_d;
  logic               mdo_q, mdo_d;
  logic               oe_q, oe_d;
  logic               done_q, done_d;
  logic [FRAME_W-1:0] frame_w;

  always_comb begin
    frame_w = {{PRE_W{1'b1}}, 2'b01, (is_read ? OP_RD : OP_WR), phy_addr, reg_addr,
               (is_read ? 2'b11 : 2'b10), (is_read ? 16'hFFFF : wdata)};
  end

  always_comb begin
    busy_d = busy_q;
    lnch_d = lnch_q;
    cnt_d  = cnt_q;
    sh_d   = sh_q;
    rd_d   = rd_q;
    rdat_d = rdat_q;
    mdo_d  = mdo_q;
    oe_d   = oe_q;
    done_d = 1'b0;
    if (!busy_q) begin
      if (fall_stb) begin
        mdo_d = 1'b1;
        oe_d  = 1'b0;
      end
      if (go) begin
        busy_d = 1'b1;
        lnch_d = 1'b0;
        cnt_d  = '0;
        rd_d   = is_read;
        sh_d   = frame_w;
      end
    end else if (fall_stb) begin
      mdo_d  = sh_q[FRAME_W-1];
      sh_d   = {sh_q[FRAME_W-2:0], 1'b1};
      oe_d   = !(rd_q && (cnt_q >= TA_POS));
      lnch_d = 1'b1;
    end else if (rise_stb && lnch_q) begin
      if (rd_q && (cnt_q >= DATA_POS)) rdat_d = {rdat_q[14:0], mdio_i};
      if (cnt_q == LAST_POS) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      lnch_q <= 1'b0;
      cnt_q  <= '0;
      sh_q   <= '0;
      rd_q   <= 1'b0;
      rdat_q <= '0;
      mdo_q  <= 1'b1;
      oe_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      lnch_q <= lnch_d;
      cnt_q  <= cnt_d;
      sh_q   <= sh_d;
      rd_q   <= rd_d;
      rdat_q <= rdat_d;
      mdo_q  <= mdo_d;
      oe_q   <= oe_d;
      done_q <= done_d;
    end
  end

  assign done    = done_q;
  assign rdata   = rdat_q;
  assign mdio_o  = mdo_q;
  assign mdio_oe = oe_q;

endmodule

// File: rtl/phy_scan_seq.sv
module phy_scan_seq
  import mdio_mgmt_pkg::*;
#(
  parameter int          NPORT    = 16,
  parameter logic [4:0]  PHY_BASE = 5'b01000,
  parameter logic [15:0] ADV_WORD = 16'h05E1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             done,
  input  logic [15:0]      rdata,
  output logic             go,
  output logic             is_read,
  output logic [4:0]       phy_addr,
  output logic [4:0]       reg_addr,
  output logic [15:0]      wdata,
  output logic [NPORT-1:0] link_o,
  output logic [NPORT-1:0] fast_o,
  output logic [NPORT-1:0] full_o,
  output logic [NPORT-1:0] pause_o
);

  localparam int PW = (NPORT > 1) ? $clog2(NPORT) : 1;
  localparam logic [PW-1:0] PORT_LAST = PW'(NPORT - 1);

  step_e         step_q, step_d;
  logic [PW-1:0] port_q, port_d;
  logic          busy_q, busy_d;
  logic          link_q, link_d;
  logic          upd;
  port_stat_t    new_stat;

  always_comb begin
    go       = !busy_q;
    phy_addr = PHY_BASE + 5'(port_q);
    case (step_q)
      STEP_ADV:     begin is_read = 1'b0; reg_addr = REG_ADV;  wdata = ADV_WORD;     end
      STEP_RESTART: begin is_read = 1'b0; reg_addr = REG_CTRL; wdata = RESTART_WORD; end
      STEP_STAT:    begin is_read = 1'b1; reg_addr = REG_STAT; wdata = '0;           end
      default:      begin is_read = 1'b1; reg_addr = REG_PART; wdata = '0;           end
    endcase
  end

  always_comb begin
    step_d   = step_q;
    port_d   = port_q;
    busy_d   = busy_q;
    link_d   = link_q;
    upd      = 1'b0;
    new_stat = resolve_port(link_q, ADV_WORD, rdata);
    if (!busy_q) begin
      busy_d = 1'b1;
    end else if (done) begin
      busy_d = 1'b0;
      case (step_q)
        STEP_ADV: step_d = STEP_RESTART;
        STEP_RESTART: begin
          if (port_q == PORT_LAST) begin
            step_d = STEP_STAT;
            port_d = '0;
          end else begin
            step_d = STEP_ADV;
            port_d = port_q + 1'b1;
          end
        end
        STEP_STAT: begin
          link_d = rdata[LINK_BIT];
          step_d = STEP_PART;
        end
        default: begin
          upd    = 1'b1;
          step_d = STEP_STAT;
          port_d = (port_q == PORT_LAST) ? '0 : port_q + 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= STEP_ADV;
      port_q <= '0;
      busy_q <= 1'b0;
      link_q <= 1'b0;
    end else begin
      step_q <= step_d;
      port_q <= port_d;
      busy_q <= busy_d;
      link_q <= link_d;
    end
  end

  for (genvar gp = 0; gp < NPORT; gp++) begin : g_port
    port_stat_t ent_q;
    logic       hit;
    assign hit = upd && (port_q == PW'(gp));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   ent_q <= '0;
      else if (hit) ent_q <= new_stat;
    end
    assign link_o[gp]  = ent_q.link;
    assign fast_o[gp]  = ent_q.fast;
    assign full_o[gp]  = ent_q.full;
    assign pause_o[gp] = ent_q.pause;
  end

endmodule

// File: rtl/phy_mgmt_master.sv
module phy_mgmt_master
  import mdio_mgmt_pkg::*;
#(
  parameter int          NPORT    = 16,
  parameter logic [4:0]  PHY_BASE = 5'b01000,
  parameter int          CLK_HALF = 25,
  parameter logic [15:0] ADV_WORD = 16'h05E1
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic             mdc,
  output logic             mdio_o,
  output logic             mdio_oe,
  input  logic             mdio_i,
  output logic [NPORT-1:0] port_link,
  output logic [NPORT-1:0] port_fast,
  output logic [NPORT-1:0] port_full,
  output logic [NPORT-1:0] port_pause
);

  logic        rst_meta_q, rst_q;
  logic        rise_stb, fall_stb;
  logic        go, is_read, done;
  logic [4:0]  phy_addr, reg_addr;
  logic [15:0] wdata, rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_q      <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_q      <= rst_meta_q;
    end
  end

  mdc_gen #(.CLK_HALF(CLK_HALF)) u_clkgen (
    .clk      (clk),
    .rst_n    (rst_q),
    .mdc      (mdc),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb)
  );

  mdio_shifter u_shift (
    .clk      (clk),
    .rst_n    (rst_q),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb),
    .go       (go),
    .is_read  (is_read),
    .phy_addr (phy_addr),
    .reg_addr (reg_addr),
    .wdata    (wdata),
    .mdio_i   (mdio_i),
    .done     (done),
    .rdata    (rdata),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe)
  );

  phy_scan_seq #(
    .NPORT    (NPORT),
    .PHY_BASE (PHY_BASE),
    .ADV_WORD (ADV_WORD)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_q),
    .done     (done),
    .rdata    (rdata),
    .go       (go),
    .is_read  (is_read),
    .phy_addr (phy_addr),
    .reg_addr (reg_addr),
    .wdata    (wdata),
    .link_o   (port_link),
    .fast_o   (port_fast),
    .full_o   (port_full),
    .pause_o  (port_pause)
  );

endmodule

// File: rtl/phy_mgmt_master_chk.sv
module phy_mgmt_master_chk #(
  parameter int NPORT    = 16,
  parameter int CLK_HALF = 25
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mdc,
  input logic             mdio_o,
  input logic             mdio_oe,
  input logic [NPORT-1:0] port_link,
  input logic [NPORT-1:0] port_fast,
  input logic [NPORT-1:0] port_full,
  input logic [NPORT-1:0] port_pause
);

  logic        mdc_d;
  logic [15:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mdc_d <= 1'b0;
      run   <= '0;
    end else begin
      mdc_d <= mdc;
      if (mdc != mdc_d)      run <= '0;
      else if (run != 16'hFFFF) run <= run + 16'd1;
    end
  end

  // R1: an MDC level never ends early
  a_r1_mdc_half: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc != mdc_d) |-> (run >= 16'(CLK_HALF - 1)));

  // R2: pin and enable move only while MDC is low
  a_r2_drive_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(mdio_o) || !$stable(mdio_oe)) |-> !mdc);

  // R8: no resolved mode without link
  a_r8_no_mode_without_link: assert property (@(posedge clk) disable iff (!rst_n)
    ((port_fast | port_full | port_pause) & ~port_link) == '0);

  // R10: pause only with full duplex
  a_r10_pause_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
    (port_pause & ~port_full) == '0);

  // R7: one port entry at a time
  a_r7_single_update: assert property (@(posedge clk) disable iff (!rst_n)
    $countones((port_link ^ $past(port_link)) | (port_fast ^ $past(port_fast)) |
               (port_full ^ $past(port_full)) | (port_pause ^ $past(port_pause))) <= 1);

endmodule

bind phy_mgmt_master phy_mgmt_master_chk #(
  .NPORT    (NPORT),
  .CLK_HALF (CLK_HALF)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_q),
  .mdc        (mdc),
  .mdio_o     (mdio_o),
  .mdio_oe    (mdio_oe),
  .port_link  (port_link),
  .port_fast  (port_fast),
  .port_full  (port_full),
  .port_pause (port_pause)
);

// File: tb/phy_mgmt_master_test.sv
module phy_mgmt_master_test;

  localparam int          NP   = 16;
  localparam int          HALF = 2;
  localparam logic [15:0] ADV  = 16'h05E1;

  logic          clk;
  logic          rst_n;
  logic          mdc, mdio_o, mdio_oe, mdi;
  logic [NP-1:0] port_link, port_fast, port_full, port_pause;

  int total = 0;
  int bad   = 0;

  logic        mlink [NP];
  logic [15:0] mpart [NP];

  phy_mgmt_master #(
    .NPORT    (NP),
    .PHY_BASE (5'b01000),
    .CLK_HALF (HALF),
    .ADV_WORD (ADV)
  ) uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .mdc        (mdc),
    .mdio_o     (mdio_o),
    .mdio_oe    (mdio_oe),
    .mdio_i     (mdi),
    .port_link  (port_link),
    .port_fast  (port_fast),
    .port_full  (port_full),
    .port_pause (port_pause)
  );

  initial begin
    clk = 1'b0;
    forever #4 clk = ~clk;
  end

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: run did not complete act=hung exp=finished");
    finish_run();
  end

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", what, act, exp);
    end
  endtask

  function automatic int pat_of(input int p, input int r);
    return (p + 3 * r) % 7;
  endfunction

  function automatic logic [15:0] part_of(input int k);
    case (k)
      0: return 16'h05E1;
      1: return 16'h0081;
      2: return 16'h0441;
      3: return 16'h05E1;
      4: return 16'h0021;
      5: return 16'h0401;
      default: return 16'h0501;
    endcase
  endfunction

  // expected {link, fast, full, pause} from R8, R9, R10
  function automatic logic [3:0] exp_stat(input int k);
    logic [15:0] c;
    logic        f, d;
    if (k == 3) return 4'b0000;
    c = ADV & part_of(k);
    f = 1'b0;
    d = 1'b0;
    if (c[8])      begin f = 1'b1; d = 1'b1; end
    else if (c[7]) begin f = 1'b1; end
    else if (c[6]) begin d = 1'b1; end
    return {1'b1, f, d, d & c[10]};
  endfunction

  task automatic set_round(input int r);
    for (int p = 0; p < NP; p++) begin
      mlink[p] = (pat_of(p, r) != 3);
      mpart[p] = part_of(pat_of(p, r));
    end
  endtask

  task automatic nxt();
    @(posedge mdc);
    @(negedge clk);
  endtask

  // decodes one frame at the pins and answers reads from the PHY model
  task automatic serve(output logic [1:0] op, output logic [4:0] pa, output logic [4:0] ra,
                       output logic [15:0] wd, output int pre, output bit fmt_ok, output bit rel_ok);
    int          ones;
    int          idx;
    logic [15:0] rsp;
    ones   = 0;
    fmt_ok = 1'b1;
    rel_ok = 1'b1;
    op = '0; pa = '0; ra = '0; wd = '0;
    forever begin
      nxt();
      if (mdio_oe && mdio_o) ones++;
      else if (mdio_oe && !mdio_o && ones >= 32) break;
      else ones = 0;
    end
    pre = ones;
    nxt();
    if (!(mdio_oe && mdio_o)) fmt_ok = 1'b0;
    for (int i = 0; i < 2; i++) begin nxt(); op = {op[0], mdio_o}; end
    for (int i = 0; i < 5; i++) begin nxt(); pa = {pa[3:0], mdio_o}; end
    for (int i = 0; i < 5; i++) begin nxt(); ra = {ra[3:0], mdio_o}; end
    if (op == 2'b10) begin
      nxt();
      if (mdio_oe) rel_ok = 1'b0;
      nxt();
      if (mdio_oe) rel_ok = 1'b0;
      idx = int'(pa) - 8;
      if (idx < 0 || idx >= NP) rsp = 16'h0000;
      else if (ra == 5'd1)      rsp = 16'h7809 | {13'h0, mlink[idx], 2'b00};
      else if (ra == 5'd5)      rsp = mpart[idx];
      else                      rsp = 16'h0000;
      mdi = rsp[15];
      for (int i = 15; i >= 0; i--) begin
        nxt();
        if (mdio_oe) rel_ok = 1'b0;
        mdi = (i > 0) ? rsp[i-1] : 1'b1;
      end
    end else begin
      nxt();
      if (!(mdio_oe && mdio_o)) fmt_ok = 1'b0;
      nxt();
      if (!(mdio_oe && !mdio_o)) fmt_ok = 1'b0;
      for (int i = 0; i < 16; i++) begin
        nxt();
        wd = {wd[14:0], mdio_o};
        if (!mdio_oe) fmt_ok = 1'b0;
      end
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b1;
    mdi   = 1'b1;
    set_round(0);
    #1 rst_n = 1'b0;
    repeat (5) @(negedge clk);
    chk(mdc == 1'b0 && mdio_oe == 1'b0, "R11 pins in reset", {mdc, mdio_oe}, 0);
    chk((port_link | port_fast | port_full | port_pause) == '0, "R11 status in reset",
        port_link | port_fast | port_full | port_pause, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mdc == 1'b0 && mdio_oe == 1'b0, "R11 pins after release", {mdc, mdio_oe}, 0);
    chk((port_link | port_fast | port_full | port_pause) == '0, "R11 status after release",
        port_link | port_fast | port_full | port_pause, 0);
  endtask

  task automatic t_init();
    logic [1:0]  op;
    logic [4:0]  pa, ra, er;
    logic [15:0] wd, ed;
    int          pre;
    bit          fmt, rel;
    for (int i = 0; i < 2 * NP; i++) begin
      serve(op, pa, ra, wd, pre, fmt, rel);
      er = (i % 2 == 1) ? 5'd0 : 5'd4;
      ed = (i % 2 == 1) ? 16'h1200 : ADV;
      chk(pre == 32 && fmt, "R3 write frame layout", pre, 32);
      chk(op == 2'b01 && pa == 5'(8 + i / 2) && ra == er && wd == ed, "R4 init sequence",
          {op, pa, ra, wd}, {2'b01, 5'(8 + i / 2), er, ed});
    end
  endtask

  task automatic t_clock();
    int n;
    nxt();
    n = 1;
    forever begin @(negedge clk); if (!mdc) break; n++; end
    chk(n == HALF, "R1 MDC high length", n, HALF);
    n = 1;
    forever begin @(negedge clk); if (mdc) break; n++; end
    chk(n == HALF, "R1 MDC low length", n, HALF);
  endtask

  task automatic t_drive_edge();
    int viol;
    viol = 0;
    for (int k = 0; k < 40; k++) begin
      logic o0, e0;
      nxt();
      o0 = mdio_o;
      e0 = mdio_oe;
      while (mdc) begin
        if (mdio_o !== o0 || mdio_oe !== e0) viol++;
        @(negedge clk);
      end
    end
    chk(viol == 0, "R2 pin moved while MDC high", viol, 0);
  endtask

  task automatic t_poll_round(input int r);
    logic [1:0]  op;
    logic [4:0]  pa, ra, er;
    logic [15:0] wd;
    int          pre;
    bit          fmt, rel;
    logic [3:0]  act;
    for (int i = 0; i < 2 * NP; i++) begin
      serve(op, pa, ra, wd, pre, fmt, rel);
      er = (i % 2 == 1) ? 5'd5 : 5'd1;
      chk(pre == 32 && op == 2'b10 && pa == 5'(8 + i / 2) && ra == er, "R6 poll order",
          {pre[7:0], op, pa, ra}, {8'd32, 2'b10, 5'(8 + i / 2), er});
      chk(rel, "R5 pin released in read", rel, 1);
    end
    set_round(r + 1);
    repeat (2) @(negedge clk);
    for (int p = 0; p < NP; p++) begin
      act = {port_link[p], port_fast[p], port_full[p], port_pause[p]};
      chk(act == exp_stat(pat_of(p, r)), "R7/R8/R9/R10 port status", act, exp_stat(pat_of(p, r)));
    end
  endtask

  initial begin
    t_reset();
    fork
      t_init();
      begin
        t_clock();
        t_drive_edge();
      end
    join
    t_poll_round(0);
    t_poll_round(1);
    finish_run();
  end

endmodule